// File: doc/BRIEF.md
# Dock Move Executor with Torpedo Kill

This block runs decoded move instructions at a fabric dock. It holds one move at a time. The move fires when its predicate holds, both downstream successors report empty, and every input the move waits on (an arriving token, an arriving data word, or both) is present. A move can repeat for as long as its predicate stays true. It can also step the loop counter down by one on each firing, and it reloads the control flag (C) either from the consumed packet's signal bit or from the ship.

A torpedo is a kill request with no payload. It is latched until a non-immune move that is waiting, and cannot fire, is held. Both are then consumed and the loop counter is cleared. The block owns the full-word loop counter and reports its zeroness as the Z flag. A move that could be killed but waits on nothing is illegal: it is flagged and dropped.

Three valid/ready channels carry the stream traffic: moves in, tokens in and data words in. The move channel is ready only while the slot is empty, so an offered move waits with `ins_valid` high until it is taken. The token and data channels are ready only in the cycle their move fires, and only for the inputs that move waits on. A source may hold valid high across any number of cycles without anything being consumed. The torpedo channel is ready only while no torpedo is pending.

Top module: `dock_move_exec`

## Requirements
- R1: `mv_fire` is high only while a move is held, its predicate holds, `dsucc_empty` and `tsucc_empty` are both 1, `tok_valid` is 1 if the move waits on a token (`ins_ti`=1), and `dat_valid` is 1 if it waits on data (`ins_di`=1). When all of these hold, `mv_fire` is high.
- R2: A firing move with `ins_dec`=1 leaves the loop counter one lower after the clock edge.
- R3: A move with `ins_rpt`=1 stays held after each firing and retires at the first cycle its predicate is false. A move with `ins_rpt`=0 retires after one firing. So a repeating, decrementing move with predicate code 1 fires exactly as many times as the counter's starting value.
- R4: A held non-immune move (`ins_imm`=0) that cannot fire while a torpedo is pending is struck. At the next edge the move and the torpedo are both gone, the loop counter is 0, and the move never fires.
- R5: An immune move (`ins_imm`=1) is never struck. It stays held until it fires, and the torpedo stays pending.
- R6: On a firing with `ins_dc`=1, C takes `ship_c`. With `ins_dc`=0, C takes `dat_sig` if the move waits on data, otherwise `tok_sig` if it waits on a token, and otherwise C is unchanged.
- R7: `z_flag` is 1 exactly when the loop counter is 0. The counter is LC_W (default 37) bits wide.
- R8: A move with `ins_imm`=0, `ins_ti`=0 and `ins_di`=0 is illegal. `bad_move` pulses in the cycle after it is accepted, the move is discarded, and the slot stays free.
- R9: An accepted torpedo stays pending, with `torp_ready` low, until it strikes. This holds even if no move is held when it arrives.
- R10: Decrementing a counter already at 0 leaves it at 0.
- R11: Predicate codes on `ins_pred`: 0 always, 1 counter nonzero, 2 counter zero, 3 never. A held move whose predicate is false retires without firing and without consuming a token or data word.
- R12: After reset no move is held, `ins_ready`=1, `torp_ready`=1, the counter is 0, Z=1 and C=0.
- R13: `lc_ld` loads `lc_ld_val` at the next edge. A strike takes priority over a load, and a load takes priority over a decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Decoded move offered |
| ins_ready | output | 1 | Slot free; the move is taken at this edge |
| ins_pred | input | 2 | Predicate code |
| ins_rpt | input | 1 | Repeat while the predicate holds |
| ins_imm | input | 1 | Immune to torpedoes |
| ins_dec | input | 1 | Decrement the counter on each firing |
| ins_ti | input | 1 | Wait for and consume a token |
| ins_di | input | 1 | Wait for and consume a data word |
| ins_dc | input | 1 | C source: 1 ship, 0 packet signal bit |
| dsucc_empty | input | 1 | Data successor empty |
| tsucc_empty | input | 1 | Token successor empty |
| tok_valid | input | 1 | Token present |
| tok_sig | input | 1 | Token signal bit |
| tok_ready | output | 1 | Token consumed this cycle |
| dat_valid | input | 1 | Data word present |
| dat_sig | input | 1 | Data signal bit |
| dat_ready | output | 1 | Data word consumed this cycle |
| torp_valid | input | 1 | Torpedo offered |
| torp_ready | output | 1 | Torpedo taken at this edge |
| ship_c | input | 1 | C value supplied by the ship |
| lc_ld | input | 1 | Load the loop counter |
| lc_ld_val | input | LC_W | Value to load |
| mv_fire | output | 1 | The move fires this cycle |
| c_flag | output | 1 | Control flag |
| z_flag | output | 1 | Counter-is-zero flag |
| lc_val | output | LC_W | Loop counter |
| bad_move | output | 1 | Illegal move dropped |

## Verification
The assertions take three things for granted. Reset starts every run. `torp_valid` and `ins_valid` are sampled only at rising edges. `lc_ld` is never raised in the same cycle as a strike the stimulus intends to observe; the priority check covers load against decrement only.

The stimulus drives every input on the falling edge, so handshakes are settled well before each sampling edge. It keeps the test moves legal wherever a legal move is intended, and sweeps counter start values, predicate codes and stall patterns on the successor-empty inputs.

// File: rtl/dock_mv_pkg.sv
package dock_mv_pkg;

  typedef enum logic [1:0] {
    PR_ALWAYS = 2'd0,
    PR_NZ     = 2'd1,
    PR_ZERO   = 2'd2,
    PR_NEVER  = 2'd3
  } pred_e;

  typedef struct packed {
    pred_e pred;
    logic  rpt;
    logic  imm;
    logic  dec;
    logic  ti;
    logic  di;
    logic  dc;
  } mv_ins_t;

  function automatic logic pred_holds(pred_e p, logic z);
    case (p)
      PR_ALWAYS: pred_holds = 1'b1;
      PR_NZ:     pred_holds = !z;
      PR_ZERO:   pred_holds = z;
      default:   pred_holds = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mv_slot.sv
module mv_slot
  import dock_mv_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ins_valid,
  input  mv_ins_t ins,
  input  logic    retire,
  input  logic    fire,
  output logic    ins_ready,
  output logic    held,
  output mv_ins_t cur,
  output logic    bad_move
);

  logic accept;
  logic illegal;

  assign ins_ready = !held;
  assign accept    = ins_valid && !held;
  assign illegal   = !ins.imm && !ins.ti && !ins.di;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      cur      <= '0;
      bad_move <= 1'b0;
    end else begin
      bad_move <= accept && illegal;
      if (held && retire) begin
        held <= 1'b0;
      end else if (accept && !illegal) begin
        held <= 1'b1;
        cur  <= ins;
      end
    end
  end

  AST_ILLEGAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && illegal) |=> (!held && bad_move)); // R8
  AST_NO_FIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> held); // R1
  AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (held && retire) |=> !held); // R3

endmodule

// File: rtl/mv_lc.sv
module mv_lc #(
  parameter int LC_W = 37
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            ld,
  input  logic [LC_W-1:0] ld_val,
  input  logic            dec,
  output logic [LC_W-1:0] lc,
  output logic            z
);

  localparam logic [LC_W-1:0] ONE = {{(LC_W-1){1'b0}}, 1'b1};

  assign z = (lc == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lc <= '0;
    end else if (clr) begin
      lc <= '0;
    end else if (ld) begin
      lc <= ld_val;
    end else if (dec && !z) begin
      lc <= lc - ONE;
    end
  end

  AST_LC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !clr && !ld && lc != '0) |=> (lc == $past(lc) - ONE)); // R2
  AST_LC_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !clr && !ld && lc == '0) |=> (lc == '0)); // R10
  AST_LC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> z); // R4

endmodule

// File: rtl/mv_torp.sv
module mv_torp (
  input  logic clk,
  input  logic rst_n,
  input  logic torp_valid,
  input  logic strike,
  output logic torp_ready,
  output logic pend
);

  assign torp_ready = !pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (strike) begin
      pend <= 1'b0;
    end else if (torp_valid && !pend) begin
      pend <= 1'b1;
    end
  end

  AST_TORP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !strike) |=> pend); // R9
  AST_STRIKE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    strike |-> pend); // R4

endmodule

// File: rtl/dock_move_exec.sv
module dock_move_exec
  import dock_mv_pkg::*;
#(
  parameter int LC_W = 37
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_valid,
  output logic            ins_ready,
  input  logic [1:0]      ins_pred,
  input  logic            ins_rpt,
  input  logic            ins_imm,
  input  logic            ins_dec,
  input  logic            ins_ti,
  input  logic            ins_di,
  input  logic            ins_dc,
  input  logic            dsucc_empty,
  input  logic            tsucc_empty,
  input  logic            tok_valid,
  input  logic            tok_sig,
  output logic            tok_ready,
  input  logic            dat_valid,
  input  logic            dat_sig,
  output logic            dat_ready,
  input  logic            torp_valid,
  output logic            torp_ready,
  input  logic            ship_c,
  input  logic            lc_ld,
  input  logic [LC_W-1:0] lc_ld_val,
  output logic            mv_fire,
  output logic            c_flag,
  output logic            z_flag,
  output logic [LC_W-1:0] lc_val,
  output logic            bad_move
);

  mv_ins_t ins_in;
  mv_ins_t cur;
  logic    held;
  logic    pend;
  logic    pok;
  logic    inputs_ok;
  logic    succ_ok;
  logic    strike;
  logic    retire;

  assign ins_in = '{pred: pred_e'(ins_pred), rpt: ins_rpt, imm: ins_imm,
                    dec: ins_dec, ti: ins_ti, di: ins_di, dc: ins_dc};

  mv_slot u_slot (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins(ins_in),
    .retire(retire), .fire(mv_fire), .ins_ready(ins_ready), .held(held),
    .cur(cur), .bad_move(bad_move)
  );

  mv_torp u_torp (
    .clk(clk), .rst_n(rst_n), .torp_valid(torp_valid), .strike(strike),
    .torp_ready(torp_ready), .pend(pend)
  );

  mv_lc #(.LC_W(LC_W)) u_lc (
    .clk(clk), .rst_n(rst_n), .clr(strike), .ld(lc_ld), .ld_val(lc_ld_val),
    .dec(mv_fire && cur.dec), .lc(lc_val), .z(z_flag)
  );

  assign pok       = pred_holds(cur.pred, z_flag);
  assign succ_ok   = dsucc_empty && tsucc_empty;
  assign inputs_ok = (!cur.ti || tok_valid) && (!cur.di || dat_valid);
  assign mv_fire   = held && pok && succ_ok && inputs_ok;
  assign strike    = held && pok && !mv_fire && !cur.imm && pend;
  assign retire    = (held && !pok) || strike || (mv_fire && !cur.rpt);
  assign tok_ready = mv_fire && cur.ti;
  assign dat_ready = mv_fire && cur.di;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_flag <= 1'b0;
    end else if (mv_fire) begin
      if (cur.dc)      c_flag <= ship_c;
      else if (cur.di) c_flag <= dat_sig;
      else if (cur.ti) c_flag <= tok_sig;
    end
  end

  AST_RPT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_fire && cur.rpt) |=> held); // R3
  AST_C_SHIP: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_fire && cur.dc) |=> (c_flag == $past(ship_c))); // R6
  AST_IMMUNE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (held && cur.imm && !mv_fire && pok) |=> held); // R5
  AST_FIRE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_ready || dat_ready) |-> (dsucc_empty && tsucc_empty)); // R1

endmodule

// File: tb/sim_dock_move_exec.sv
`timescale 1ns/1ps
module sim_dock_move_exec;
  localparam int LC_W = 37;

  logic clk = 0;
  logic rst_n = 0;
  logic ins_valid = 0, ins_rpt = 0, ins_imm = 0, ins_dec = 0, ins_ti = 0, ins_di = 0, ins_dc = 0;
  logic [1:0] ins_pred = 0;
  logic dsucc_empty = 1, tsucc_empty = 1;
  logic tok_valid = 0, tok_sig = 0, dat_valid = 0, dat_sig = 0;
  logic torp_valid = 0, ship_c = 0, lc_ld = 0;
  logic [LC_W-1:0] lc_ld_val = '0;
  logic ins_ready, tok_ready, dat_ready, torp_ready, mv_fire, c_flag, z_flag, bad_move;
  logic [LC_W-1:0] lc_val;

  int checks = 0;
  int errors = 0;
  int fires = 0;

  always #4 clk = ~clk;

  dock_move_exec #(.LC_W(LC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_pred(ins_pred), .ins_rpt(ins_rpt), .ins_imm(ins_imm), .ins_dec(ins_dec),
    .ins_ti(ins_ti), .ins_di(ins_di), .ins_dc(ins_dc),
    .dsucc_empty(dsucc_empty), .tsucc_empty(tsucc_empty),
    .tok_valid(tok_valid), .tok_sig(tok_sig), .tok_ready(tok_ready),
    .dat_valid(dat_valid), .dat_sig(dat_sig), .dat_ready(dat_ready),
    .torp_valid(torp_valid), .torp_ready(torp_ready), .ship_c(ship_c),
    .lc_ld(lc_ld), .lc_ld_val(lc_ld_val), .mv_fire(mv_fire), .c_flag(c_flag),
    .z_flag(z_flag), .lc_val(lc_val), .bad_move(bad_move)
  );

  always @(posedge clk) if (rst_n && mv_fire) fires <= fires + 1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_lc(input logic [LC_W-1:0] v);
    @(negedge clk);
    lc_ld = 1; lc_ld_val = v;
    @(negedge clk);
    lc_ld = 0;
  endtask

  task automatic issue(input logic [1:0] p, input logic r, input logic im, input logic d,
                       input logic ti, input logic di, input logic dc);
    @(negedge clk);
    ins_valid = 1; ins_pred = p; ins_rpt = r; ins_imm = im; ins_dec = d;
    ins_ti = ti; ins_di = di; ins_dc = dc;
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic torpedo();
    @(negedge clk);
    torp_valid = 1;
    @(negedge clk);
    torp_valid = 0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f0;
    int bad_fires;
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R12 reset state
    check("R12 ins_ready", ins_ready, 1);
    check("R12 torp_ready", torp_ready, 1);
    check("R12 lc", lc_val, 0);
    check("R12 z", z_flag, 1);
    check("R12 c", c_flag, 0);

    // R3 R2 R7: repeating decrementing move fires as many times as the start value
    for (int n = 0; n <= 6; n++) begin
      load_lc(LC_W'(n));
      check("R13 load", lc_val, n);
      f0 = fires;
      issue(2'd1, 1, 1, 1, 0, 0, 1);
      cyc(n + 4);
      check("R3 repeat count", fires - f0, n);
      check("R2 lc drained", lc_val, 0);
      check("R7 z at zero", z_flag, 1);
      check("R3 retired", ins_ready, 1);
    end

    // R1 stalls on the successor-empty inputs
    for (int n = 1; n <= 4; n++) begin
      load_lc(LC_W'(n));
      f0 = fires;
      bad_fires = 0;
      issue(2'd1, 1, 1, 1, 0, 0, 1);
      for (int k = 0; k < 2 * n + 6; k++) begin
        dsucc_empty = k[0];
        tsucc_empty = (k % 3) != 0;
        #1;
        if (mv_fire && !(dsucc_empty && tsucc_empty)) bad_fires++;
        @(negedge clk);
      end
      dsucc_empty = 1; tsucc_empty = 1;
      cyc(n + 3);
      check("R1 no fire while stalled", bad_fires, 0);
      check("R1 stalled repeat count", fires - f0, n);
    end

    // R11 R10 R2 R7: predicate codes against counter 0 and 3
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 2; s++) begin
        int start;
        int exp_f;
        int exp_lc;
        start = s * 3;
        load_lc(LC_W'(start));
        f0 = fires;
        issue(p[1:0], 0, 1, 1, 0, 0, 1);
        cyc(3);
        case (p)
          0: exp_f = 1;
          1: exp_f = (start != 0) ? 1 : 0;
          2: exp_f = (start == 0) ? 1 : 0;
          default: exp_f = 0;
        endcase
        exp_lc = (exp_f == 1 && start > 0) ? start - 1 : start;
        check("R11 predicate fire count", fires - f0, exp_f);
        check("R10 lc after move", lc_val, exp_lc);
        check("R7 z flag", z_flag, (exp_lc == 0) ? 1 : 0);
        check("R11 retired", ins_ready, 1);
      end
    end

    // R11: false predicate consumes nothing
    tok_valid = 1;
    issue(2'd3, 0, 1, 0, 1, 0, 0);
    #1;
    check("R11 no token consumed", tok_ready, 0);
    tok_valid = 0;
    cyc(2);

    // R6: C source sweep
    for (int v = 0; v < 48; v++) begin
      logic ti, di, dc, ts, ds, sc;
      logic exp_c;
      logic prev_c;
      ti = (v % 3) != 1;
      di = (v % 3) != 0;
      dc = v[2]; ts = v[3]; ds = v[4]; sc = v[5] ^ v[0];
      tok_valid = 1; dat_valid = 1; tok_sig = ts; dat_sig = ds; ship_c = sc;
      prev_c = c_flag;
      f0 = fires;
      issue(2'd0, 0, 1, 0, ti, di, dc);
      cyc(2);
      exp_c = dc ? sc : (di ? ds : (ti ? ts : prev_c));
      check("R6 c flag", c_flag, exp_c);
      check("R1 single fire", fires - f0, 1);
    end
    tok_valid = 0; dat_valid = 0;

    // R13: load beats decrement in the same cycle
    load_lc(LC_W'(4));
    @(negedge clk);
    ins_valid = 1; ins_pred = 0; ins_rpt = 0; ins_imm = 1; ins_dec = 1;
    ins_ti = 0; ins_di = 0; ins_dc = 1;
    @(negedge clk);
    ins_valid = 0; lc_ld = 1; lc_ld_val = LC_W'(9);
    @(negedge clk);
    lc_ld = 0;
    check("R13 load over decrement", lc_val, 9);
    check("R7 z clear", z_flag, 0);

    // R8 illegal move
    f0 = fires;
    tok_valid = 1; dat_valid = 1;
    issue(2'd0, 0, 0, 0, 0, 0, 0);
    check("R8 bad_move pulse", bad_move, 1);
    check("R8 slot free", ins_ready, 1);
    cyc(2);
    check("R8 bad_move one cycle", bad_move, 0);
    check("R8 no fire", fires - f0, 0);
    tok_valid = 0; dat_valid = 0;

    // R4 strike of a waiting non-immune move
    load_lc(LC_W'(5));
    f0 = fires;
    issue(2'd0, 0, 0, 1, 1, 0, 0);
    cyc(3);
    check("R4 move waits", ins_ready, 0);
    check("R4 lc before strike", lc_val, 5);
    torpedo();
    cyc(1);
    check("R4 lc cleared", lc_val, 0);
    check("R4 z set", z_flag, 1);
    check("R4 move consumed", ins_ready, 1);
    check("R4 torpedo consumed", torp_ready, 1);
    check("R4 never fired", fires - f0, 0);

    // R9 R5: pending torpedo, immune move survives
    load_lc(LC_W'(6));
    torpedo();
    cyc(3);
    check("R9 torpedo pending", torp_ready, 0);
    f0 = fires;
    issue(2'd0, 0, 1, 0, 1, 0, 0);
    cyc(3);
    check("R5 immune held", ins_ready, 0);
    check("R5 lc kept", lc_val, 6);
    check("R9 still pending", torp_ready, 0);
    @(negedge clk);
    tok_valid = 1;
    @(negedge clk);
    tok_valid = 0;
    cyc(1);
    check("R5 immune fired", fires - f0, 1);
    check("R5 retired", ins_ready, 1);
    check("R9 pending after immune", torp_ready, 0);
    issue(2'd0, 0, 0, 0, 1, 0, 0);
    cyc(1);
    check("R4 late strike lc", lc_val, 0);
    check("R4 late strike torp", torp_ready, 1);
    check("R4 late strike slot", ins_ready, 1);
    check("R4 late strike no fire", fires - f0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule